// File: doc/BRIEF.md
# Fault supervisor with latchoff

This block decides whether a power converter's output stage may be switched on. It watches six monitor flags, each already reduced to valid (1) or invalid (0) by an external comparator. Every flag is brought into the clock domain and filtered against glitches before use. The flags then fall into two groups. The first group must stay valid for a programmed delay before the output may turn on. Any flag in the second group that goes invalid latches the block off until a deliberate unlatch request clears it.

A run input gates the output directly and bypasses every delay. One programmed duration serves two purposes. It is the qualification delay for the first group, and it is the timeout used when an unlatch request arrives while a latching fault is still present. A mode input moves the temperature flag from the first group to the second. Three status outputs report the enable, the latched state and whether a delay is counting.

None of the signals carries a data stream, so every port is a plain level signal with no handshake.

Top module: `fault_supervisor`

## Requirements
- R1: `out_en_o` is 1 only when `run_i` is 1, the nonlatching group has completed its qualification delay, and `latched_o` is 0.
- R2: `run_i` acts on `out_en_o` in the same cycle and passes through no delay, filter or register.
- R3: The nonlatching group is `drv_ok_i`, `uv_ok_i`, `ovr_ok_i`, and `temp_ok_i` when `temp_latch_i` is 0. If any of these goes invalid after filtering, `out_en_o` drops in the cycle the filtered flag falls. The qualification delay then restarts from its full length.
- R4: The latching group is `ovl_ok_i`, `crow_ok_i`, and `temp_ok_i` when `temp_latch_i` is 1. If any of these is invalid after filtering, `latched_o` is set at the next clock edge.
- R5: A rising edge on `unlatch_i` (0 in the previous cycle, 1 now) clears `latched_o` at that edge when the whole filtered latching group is valid.
- R6: A rising edge on `unlatch_i` while a latching flag is invalid has no effect on its own. The latch clears at the edge after the latching group has stayed continuously valid for the full delay, and only if `unlatch_i` is 1 at that edge. If `unlatch_i` is 0 at that point, the block stays latched until the next rising edge.
- R7: The delay length is D = `delay_cfg_i` clock cycles, or `MIN_DELAY` (16) cycles when `delay_cfg_i` is 0. The enable rises D edges after the filtered nonlatching group becomes valid.
- R8: `temp_latch_i` = 1 places the temperature flag only in the latching group. `temp_latch_i` = 0 places it only in the nonlatching group.
- R9: Each monitor passes through a 2-stage synchronizer and then a filter that changes its output only after 4 equal consecutive synchronized samples. A raw change that holds for L edges shows up at the filter output 7 edges after the first of them, provided L >= 4. A pulse shorter than 4 cycles is ignored.
- R10: During reset and right after it, `latched_o` is 1, `out_en_o` is 0 and `delay_busy_o` is 0. Every filtered flag starts invalid.
- R11: `delay_busy_o` is 1 while the qualification delay counts with the nonlatching group valid, or while the timeout counts with the block latched. Otherwise it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_i | input | 1 | Direct enable, synchronous to clk |
| drv_ok_i | input | 1 | Driver supply good (1 = valid) |
| uv_ok_i | input | 1 | Input above undervoltage level |
| ovr_ok_i | input | 1 | Input below retrying overvoltage level |
| temp_ok_i | input | 1 | Temperature good |
| ovl_ok_i | input | 1 | Input below latching overvoltage level |
| crow_ok_i | input | 1 | Crowbar not active |
| temp_latch_i | input | 1 | 1: temperature flag latches; 0: it is nonlatching |
| unlatch_i | input | 1 | Unlatch request, synchronous to clk |
| delay_cfg_i | input | CNT_W | Delay length in cycles; 0 selects MIN_DELAY |
| out_en_o | output | 1 | Converter output enable |
| latched_o | output | 1 | Latched-off state |
| delay_busy_o | output | 1 | A delay is counting |

## Verification
The bench builds the block with `CNT_W` = 8 and keeps `MIN_DELAY` = 16 and the default filter depth. A narrow counter keeps every delay at a few tens of cycles. This lets the bench measure both exact enable edges, the qualification delay and the timeout release, for a programmed length of 20 and for the zero-selects-minimum case inside one short run. Random pulse lengths between 1 and 8 cycles on randomly chosen monitors straddle the 4-sample filter threshold, so the bench sees both ignored glitches and real faults in each group.

// File: rtl/fsup_pkg.sv
package fsup_pkg;
  localparam int MON_N     = 6;
  localparam int IDX_DRV   = 0;
  localparam int IDX_UV    = 1;
  localparam int IDX_OVR   = 2;
  localparam int IDX_TEMP  = 3;
  localparam int IDX_OVL   = 4;
  localparam int IDX_CROW  = 5;

  typedef logic [MON_N-1:0] mon_vec_t;
endpackage

// File: rtl/fsup_mon_filter.sv
module fsup_mon_filter #(
  parameter int W      = 6,
  parameter int SYNC_N = 2,
  parameter int FILT_N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw_i,
  output logic [W-1:0] flt_o
);
  for (genvar b = 0; b < W; b++) begin : g_ch
    logic [SYNC_N-1:0] sync_q;
    logic [FILT_N-1:0] hist_q;
    logic              flt_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sync_q <= '0;
        hist_q <= '0;
        flt_q  <= 1'b0;
      end else begin
        sync_q <= {sync_q[SYNC_N-2:0], raw_i[b]};
        hist_q <= {hist_q[FILT_N-2:0], sync_q[SYNC_N-1]};
        if (&hist_q)
          flt_q <= 1'b1;
        else if (~|hist_q)
          flt_q <= 1'b0;
      end
    end

    assign flt_o[b] = flt_q;
  end
endmodule

// File: rtl/fsup_delay_timer.sv
module fsup_delay_timer #(
  parameter int CNT_W     = 24,
  parameter int MIN_DELAY = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cfg_i,
  input  logic             qual_i,
  output logic             done_o,
  output logic             busy_o
);
  localparam logic [CNT_W-1:0] MIN_V = CNT_W'(MIN_DELAY);

  logic [CNT_W-1:0] dur;
  logic [CNT_W-1:0] cnt_q;

  assign dur = (cfg_i == '0) ? MIN_V : cfg_i;

  // Reset to the largest count: never shorter than intended.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '1;
    else if (!qual_i)
      cnt_q <= dur;
    else if (cnt_q != '0)
      cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = qual_i && (cnt_q == '0);
  assign busy_o = qual_i && (cnt_q != '0);
endmodule

// File: rtl/fsup_latch_ctrl.sv
module fsup_latch_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic lo_bad_i,
  input  logic unlatch_i,
  input  logic tmo_done_i,
  output logic latched_o
);
  logic unl_q;
  logic unl_rise;

  assign unl_rise = unlatch_i && !unl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unl_q     <= 1'b1;
      latched_o <= 1'b1;
    end else begin
      unl_q <= unlatch_i;
      if (lo_bad_i)
        latched_o <= 1'b1;
      else if (unl_rise)
        latched_o <= 1'b0;
      else if (unlatch_i && tmo_done_i)
        latched_o <= 1'b0;
    end
  end
endmodule

// File: rtl/fault_supervisor.sv
module fault_supervisor
  import fsup_pkg::*;
#(
  parameter int CNT_W       = 24,
  parameter int MIN_DELAY   = 16,
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             drv_ok_i,
  input  logic             uv_ok_i,
  input  logic             ovr_ok_i,
  input  logic             temp_ok_i,
  input  logic             ovl_ok_i,
  input  logic             crow_ok_i,
  input  logic             temp_latch_i,
  input  logic             unlatch_i,
  input  logic [CNT_W-1:0] delay_cfg_i,
  output logic             out_en_o,
  output logic             latched_o,
  output logic             delay_busy_o
);
  mon_vec_t mon_raw;
  mon_vec_t mon_flt;
  logic     nl_ok;
  logic     lo_bad;
  logic     por_done, por_busy;
  logic     tmo_done, tmo_busy;

  always_comb begin
    mon_raw           = '0;
    mon_raw[IDX_DRV]  = drv_ok_i;
    mon_raw[IDX_UV]   = uv_ok_i;
    mon_raw[IDX_OVR]  = ovr_ok_i;
    mon_raw[IDX_TEMP] = temp_ok_i;
    mon_raw[IDX_OVL]  = ovl_ok_i;
    mon_raw[IDX_CROW] = crow_ok_i;
  end

  fsup_mon_filter #(
    .W(MON_N), .SYNC_N(SYNC_STAGES), .FILT_N(FILT_LEN)
  ) u_filt (
    .clk(clk), .rst_n(rst_n), .raw_i(mon_raw), .flt_o(mon_flt)
  );

  // Class membership of the temperature flag follows the mode input.
  assign nl_ok  = mon_flt[IDX_DRV] && mon_flt[IDX_UV] && mon_flt[IDX_OVR]
               && (temp_latch_i || mon_flt[IDX_TEMP]);
  assign lo_bad = !mon_flt[IDX_OVL] || !mon_flt[IDX_CROW]
               || (temp_latch_i && !mon_flt[IDX_TEMP]);

  fsup_delay_timer #(.CNT_W(CNT_W), .MIN_DELAY(MIN_DELAY)) u_por (
    .clk(clk), .rst_n(rst_n), .cfg_i(delay_cfg_i), .qual_i(nl_ok),
    .done_o(por_done), .busy_o(por_busy)
  );

  fsup_delay_timer #(.CNT_W(CNT_W), .MIN_DELAY(MIN_DELAY)) u_tmo (
    .clk(clk), .rst_n(rst_n), .cfg_i(delay_cfg_i), .qual_i(!lo_bad),
    .done_o(tmo_done), .busy_o(tmo_busy)
  );

  fsup_latch_ctrl u_latch (
    .clk(clk), .rst_n(rst_n), .lo_bad_i(lo_bad), .unlatch_i(unlatch_i),
    .tmo_done_i(tmo_done), .latched_o(latched_o)
  );

  assign out_en_o     = run_i && por_done && !latched_o;
  assign delay_busy_o = por_busy || (latched_o && tmo_busy);
endmodule

// File: rtl/fsup_checker.sv
module fsup_checker #(
  parameter int CNT_W     = 24,
  parameter int MIN_DELAY = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run_i,
  input logic             unlatch_i,
  input logic             temp_latch_i,
  input logic [CNT_W-1:0] delay_cfg_i,
  input logic [5:0]       flt_i,
  input logic             out_en_o,
  input logic             latched_o
);
  logic           nl_all;
  logic           lo_all;
  logic [CNT_W:0] nl_run;
  logic [CNT_W:0] need;

  assign nl_all = flt_i[0] & flt_i[1] & flt_i[2] & (flt_i[3] | temp_latch_i);
  assign lo_all = flt_i[4] & flt_i[5] & (flt_i[3] | !temp_latch_i);
  assign need   = (delay_cfg_i == '0) ? (CNT_W+1)'(MIN_DELAY) : {1'b0, delay_cfg_i};

  // Saturating count of consecutive cycles with the nonlatching group valid.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      nl_run <= '0;
    else if (!nl_all)
      nl_run <= '0;
    else if (nl_run != '1)
      nl_run <= nl_run + 1'b1;
  end

  AST_RUN_LOW_NO_EN: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |-> !out_en_o); // R2
  AST_LATCH_NO_EN: assert property (@(posedge clk) disable iff (!rst_n)
    latched_o |-> !out_en_o); // R1
  AST_EN_NEEDS_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
    out_en_o |-> nl_all); // R3
  AST_EN_AFTER_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    out_en_o |-> (nl_run >= need)); // R7
  AST_FAULT_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
    !lo_all |=> latched_o); // R4
  AST_CLEAR_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(latched_o) |-> $past(lo_all)); // R5
  AST_CLEAR_NEEDS_UNLATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(latched_o) |-> $past(unlatch_i)); // R6
endmodule

bind fault_supervisor fsup_checker #(
  .CNT_W(CNT_W), .MIN_DELAY(MIN_DELAY)
) u_fsup_chk (
  .clk(clk), .rst_n(rst_n), .run_i(run_i), .unlatch_i(unlatch_i),
  .temp_latch_i(temp_latch_i), .delay_cfg_i(delay_cfg_i), .flt_i(mon_flt),
  .out_en_o(out_en_o), .latched_o(latched_o)
);

// File: tb/fault_supervisor_bench.sv
module fault_supervisor_bench;
  localparam int CW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run = 1'b0, drv = 1'b0, uv = 1'b0, ovr = 1'b0, tmp = 1'b0;
  logic ovl = 1'b0, crow = 1'b0, tmode = 1'b0, unl = 1'b0;
  logic [CW-1:0] cfg = CW'(20);
  logic out_en, latched, busy;
  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  fault_supervisor #(.CNT_W(CW), .MIN_DELAY(16)) u_fault_supervisor (
    .clk(clk), .rst_n(rst_n), .run_i(run), .drv_ok_i(drv), .uv_ok_i(uv),
    .ovr_ok_i(ovr), .temp_ok_i(tmp), .ovl_ok_i(ovl), .crow_ok_i(crow),
    .temp_latch_i(tmode), .unlatch_i(unl), .delay_cfg_i(cfg),
    .out_en_o(out_en), .latched_o(latched), .delay_busy_o(busy)
  );

  function automatic int exp_dur(input int c);
    return (c == 0) ? 16 : c;
  endfunction

  function automatic bit pulse_seen(input int len);
    return len >= 4;
  endfunction

  function automatic bit is_latching(input int idx, input bit mode);
    return (idx == 4) || (idx == 5) || (idx == 3 && mode);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic set_mon(input int idx, input logic v);
    case (idx)
      0: drv = v;
      1: uv = v;
      2: ovr = v;
      3: tmp = v;
      4: ovl = v;
      default: crow = v;
    endcase
  endtask

  task automatic unlatch_pulse();
    unl = 1'b0;
    step(1);
    unl = 1'b1;
    step(1);
    unl = 1'b0;
  endtask

  initial begin
    #400000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int d;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    chk("R10 latched after reset", latched, 1);
    chk("R10 enable after reset", out_en, 0);
    chk("R10 busy after reset", busy, 0);

    // Bring monitors up; latch still set from reset.
    {drv, uv, ovr, tmp, ovl, crow} = 6'b111111;
    run = 1'b1;
    step(8);
    chk("R11 busy while qualifying", busy, 1);
    chk("R1 no enable while latched", out_en, 0);
    unl = 1'b1;
    step(1);
    chk("R5 immediate unlatch", latched, 0);
    step(40);
    chk("R1 enable when all conditions hold", out_en, 1);
    unl = 1'b0;
    step(1);

    // Exact drop and requalification timing, D = 20.
    d = exp_dur(20);
    uv = 1'b0;
    step(6);
    chk("R9 enable before filter latency", out_en, 1);
    step(1);
    chk("R3 enable drops on nonlatching fault", out_en, 0);
    uv = 1'b1;
    step(10);
    chk("R11 busy during restart", busy, 1);
    step(d - 4);
    chk("R7 enable one edge early", out_en, 0);
    step(1);
    chk("R7 enable at full delay", out_en, 1);
    chk("R11 busy cleared", busy, 0);

    // Zero configuration selects the 16-cycle minimum.
    cfg = '0;
    d = exp_dur(0);
    drv = 1'b0;
    step(7);
    chk("R3 drop with min delay", out_en, 0);
    drv = 1'b1;
    step(6 + d);
    chk("R7 min delay one edge early", out_en, 0);
    step(1);
    chk("R7 min delay reached", out_en, 1);

    // Latching fault timing.
    crow = 1'b0;
    step(7);
    chk("R9 latch not yet set", latched, 0);
    step(1);
    chk("R4 crowbar latches", latched, 1);
    chk("R1 latched blocks enable", out_en, 0);
    crow = 1'b1;
    step(30);
    chk("R6 stays latched without unlatch", latched, 1);
    unl = 1'b1;
    step(1);
    chk("R5 rising edge clears", latched, 0);
    unl = 1'b0;

    // Unlatch raised while invalid, cleared by timeout.
    ovl = 1'b0;
    step(10);
    chk("R4 overvoltage latches", latched, 1);
    unl = 1'b1;
    step(5);
    chk("R6 edge while invalid ignored", latched, 1);
    ovl = 1'b1;
    step(7 + d);
    chk("R6 timeout one edge early", latched, 1);
    step(1);
    chk("R6 timeout releases latch", latched, 0);

    // Unlatch dropped before timeout: stays latched.
    ovl = 1'b0;
    step(10);
    unl = 1'b0;
    step(1);
    unl = 1'b1;
    step(2);
    ovl = 1'b1;
    step(10);
    unl = 1'b0;
    step(40);
    chk("R6 no release with unlatch low", latched, 1);
    unl = 1'b1;
    step(1);
    chk("R5 later edge releases", latched, 0);
    unl = 1'b0;
    step(30);

    // Temperature class selection.
    tmode = 1'b1;
    tmp = 1'b0;
    step(10);
    chk("R8 temp latches in latch mode", latched, 1);
    tmp = 1'b1;
    step(10);
    unlatch_pulse();
    chk("R8 released after temp recovers", latched, 0);
    chk("R8 qualification untouched in latch mode", out_en, 1);
    tmode = 1'b0;
    step(2);
    tmp = 1'b0;
    step(10);
    chk("R8 temp does not latch in nonlatch mode", latched, 0);
    chk("R8 temp drops enable in nonlatch mode", out_en, 0);
    tmp = 1'b1;
    step(40);
    chk("R8 enable returns", out_en, 1);

    // Run acts without delay.
    for (int i = 0; i < 60; i++) begin
      run = 1'($urandom_range(0, 1));
      #1;
      chk("R2 run immediate", out_en, {31'b0, run});
      @(negedge clk);
    end
    run = 1'b1;
    step(1);

    // Random pulses around the filter threshold.
    for (int i = 0; i < 40; i++) begin
      int idx;
      int len;
      bit lat;
      bit seen;
      idx = $urandom_range(0, 5);
      len = $urandom_range(1, 8);
      lat = is_latching(idx, 1'b0);
      seen = pulse_seen(len);
      set_mon(idx, 1'b0);
      step(len);
      set_mon(idx, 1'b1);
      step(8);
      if (lat) begin
        chk("R4 R9 random latch pulse", latched, {31'b0, seen});
      end else begin
        chk("R3 R9 random nonlatch pulse", latched, 0);
      end
      chk("R9 random pulse enable", out_en, {31'b0, !seen});
      step(30);
      if (latched) unlatch_pulse();
      step(2);
      chk("R1 recovered after pulse", out_en, 1);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule